// File: doc/BRIEF.md
# Dual-Byte Tristate Line Driver Datapath

This block is the system-side datapath of a bus driver that carries two independent 9-bit bytes, A and B. Each byte has a data input bus, an output data bus, an output-enable flag that stands in for a real tristate output, and a pair of active-low enable pins. In normal operation the pins of a byte are merged into one active-high internal enable. When that enable is on, the input data passes to the output unchanged. When it is off, the byte's outputs are treated as high impedance.

For hot insertion, each byte also holds its outputs off after power-up, which is modelled here by reset. The outputs stay off until an enable pin of that byte is seen moving from inactive to active. A pin that simply sits low since power-up never turns the outputs on. Separately for each byte, the boundary-scan logic can take over both the output data and the enable with values from its update latches.

Top module: `dual_byte_line_driver`

## Requirements
- R1: The two bytes are independent. No change on byte A's data, pins or test inputs alters byte B's outputs, and the reverse also holds.
- R2: In system mode (test select low), a byte's output enable is 0 whenever either of its two active-low enable pins is 1.
- R3: While a byte's output enable is 1 in system mode, each output bit equals the input bit of the same index, with no inversion. While the enable is 0, the output data bus reads all zeros.
- R4: After reset, a byte stays disabled while both pins are held low, however long that lasts. It becomes enabled in the first cycle where a pin that was 1 at the previous clock edge is now 0 and the other pin is also 0. Pin levels are taken as low at reset.
- R5: Once a byte has been enabled this way, it stays armed until the next reset. From then on its enable simply follows "both pins low", with no further edge needed.
- R6: When a byte's test select is 1, its output enable equals its test enable input and its output data equals its test data, whatever the pins or armed state. The output data still reads zero when the test enable is 0.
- R7: While rst_n is 0, both output enables are 0, even in test mode, and both bytes lose their armed state.
- R8: A falling transition on either of the two pins of a byte can arm it, pin 0 or pin 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the enable pins |
| rst_n | input | 1 | Active-low asynchronous reset, models power-up |
| a_din | input | 9 | Byte A system data in |
| a_en_n | input | 2 | Byte A active-low enable pins |
| a_test_sel | input | 1 | Byte A test override select |
| a_test_data | input | 9 | Byte A test output data |
| a_test_oe | input | 1 | Byte A test output enable |
| b_din | input | 9 | Byte B system data in |
| b_en_n | input | 2 | Byte B active-low enable pins |
| b_test_sel | input | 1 | Byte B test override select |
| b_test_data | input | 9 | Byte B test output data |
| b_test_oe | input | 1 | Byte B test output enable |
| a_dout | output | 9 | Byte A output data (zero when disabled) |
| a_oe | output | 1 | Byte A output enable (0 = high impedance) |
| b_dout | output | 9 | Byte B output data (zero when disabled) |
| b_oe | output | 1 | Byte B output enable (0 = high impedance) |

## Verification
Directed sequences hold both pins low from reset and then raise and lower each pin in turn. This separates a byte that needs a real edge from one that accepts a static low level, and shows that pin 0 and pin 1 can each arm the byte. Further sequences enable one byte while the other stays untouched, apply a test override to an unarmed byte, and assert reset in the middle of a run, which shows whether the armed state and the override are kept per byte. Random phases then toggle pins, selects, data and occasional resets. Both buses are compared every cycle, so inverted, swapped or stale data bits show up.

// File: rtl/ldrv_pkg.sv
package ldrv_pkg;

    // Output source of one byte lane
    typedef enum logic {
        SRC_SYSTEM = 1'b0,
        SRC_TEST   = 1'b1
    } src_e;

    localparam int unsigned DEF_DATA_W  = 9;
    localparam int unsigned DEF_EN_PINS = 2;

endpackage

// File: rtl/ldrv_enable_merge.sv
module ldrv_enable_merge #(
    parameter int unsigned EN_PINS = 2
) (
    input  logic [EN_PINS-1:0] en_n,
    input  logic [EN_PINS-1:0] prev_q,
    output logic               all_low,
    output logic               fall_event
);

    logic [EN_PINS-1:0] fell;

    always_comb begin
        // A pin fell if it was high at the last edge and is low now
        fell       = prev_q & ~en_n;
        all_low    = ~|en_n;
        fall_event = all_low & (|fell);
    end

endmodule

// File: rtl/ldrv_arm_lock.sv
module ldrv_arm_lock #(
    parameter int unsigned EN_PINS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EN_PINS-1:0] en_n,
    input  logic               fall_event,
    output logic [EN_PINS-1:0] prev_q_o,
    output logic               armed_o
);

    typedef struct packed {
        logic               armed;
        logic [EN_PINS-1:0] prev;
    } lock_st_t;

    lock_st_t st_d;
    lock_st_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = en_n;
        if (fall_event) begin
            st_d.armed = 1'b1;
        end
    end

    // Reset value: unarmed, pin history treated as low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prev_q_o = st_q.prev;
    assign armed_o  = st_q.armed;

endmodule

// File: rtl/ldrv_out_select.sv
module ldrv_out_select
    import ldrv_pkg::*;
#(
    parameter int unsigned DATA_W = 9
) (
    input  logic              rst_n,
    input  logic              armed,
    input  logic              all_low,
    input  logic              fall_event,
    input  logic [DATA_W-1:0] sys_data,
    input  logic              test_sel,
    input  logic [DATA_W-1:0] test_data,
    input  logic              test_oe,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);

    src_e              src;
    logic              sys_oe;
    logic              sel_oe;
    logic [DATA_W-1:0] sel_data;

    always_comb begin
        src    = test_sel ? SRC_TEST : SRC_SYSTEM;
        sys_oe = all_low & (armed | fall_event);
        unique case (src)
            SRC_TEST: begin
                sel_oe   = test_oe;
                sel_data = test_data;
            end
            default: begin
                sel_oe   = sys_oe;
                sel_data = sys_data;
            end
        endcase
        oe   = sel_oe & rst_n;
        dout = oe ? sel_data : '0;
    end

endmodule

// File: rtl/ldrv_lane.sv
module ldrv_lane #(
    parameter int unsigned DATA_W  = 9,
    parameter int unsigned EN_PINS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  din,
    input  logic [EN_PINS-1:0] en_n,
    input  logic               test_sel,
    input  logic [DATA_W-1:0]  test_data,
    input  logic               test_oe,
    output logic [DATA_W-1:0]  dout,
    output logic               oe
);

    logic [EN_PINS-1:0] prev_q;
    logic               armed;
    logic               all_low;
    logic               fall_event;

    ldrv_enable_merge #(.EN_PINS(EN_PINS)) merge_i (
        .en_n       (en_n),
        .prev_q     (prev_q),
        .all_low    (all_low),
        .fall_event (fall_event)
    );

    ldrv_arm_lock #(.EN_PINS(EN_PINS)) lock_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_n       (en_n),
        .fall_event (fall_event),
        .prev_q_o   (prev_q),
        .armed_o    (armed)
    );

    ldrv_out_select #(.DATA_W(DATA_W)) sel_i (
        .rst_n      (rst_n),
        .armed      (armed),
        .all_low    (all_low),
        .fall_event (fall_event),
        .sys_data   (din),
        .test_sel   (test_sel),
        .test_data  (test_data),
        .test_oe    (test_oe),
        .dout       (dout),
        .oe         (oe)
    );

endmodule

// File: rtl/dual_byte_line_driver.sv
module dual_byte_line_driver #(
    parameter int unsigned DATA_W  = ldrv_pkg::DEF_DATA_W,
    parameter int unsigned EN_PINS = ldrv_pkg::DEF_EN_PINS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  a_din,
    input  logic [EN_PINS-1:0] a_en_n,
    input  logic               a_test_sel,
    input  logic [DATA_W-1:0]  a_test_data,
    input  logic               a_test_oe,
    input  logic [DATA_W-1:0]  b_din,
    input  logic [EN_PINS-1:0] b_en_n,
    input  logic               b_test_sel,
    input  logic [DATA_W-1:0]  b_test_data,
    input  logic               b_test_oe,
    output logic [DATA_W-1:0]  a_dout,
    output logic               a_oe,
    output logic [DATA_W-1:0]  b_dout,
    output logic               b_oe
);

    localparam int unsigned LANES = 2;

    logic [LANES-1:0][DATA_W-1:0]  din_v;
    logic [LANES-1:0][EN_PINS-1:0] en_v;
    logic [LANES-1:0]              tsel_v;
    logic [LANES-1:0][DATA_W-1:0]  tdat_v;
    logic [LANES-1:0]              toe_v;
    logic [LANES-1:0][DATA_W-1:0]  dout_v;
    logic [LANES-1:0]              oe_v;

    assign din_v  = {b_din, a_din};
    assign en_v   = {b_en_n, a_en_n};
    assign tsel_v = {b_test_sel, a_test_sel};
    assign tdat_v = {b_test_data, a_test_data};
    assign toe_v  = {b_test_oe, a_test_oe};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ldrv_lane #(
            .DATA_W  (DATA_W),
            .EN_PINS (EN_PINS)
        ) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .din       (din_v[g]),
            .en_n      (en_v[g]),
            .test_sel  (tsel_v[g]),
            .test_data (tdat_v[g]),
            .test_oe   (toe_v[g]),
            .dout      (dout_v[g]),
            .oe        (oe_v[g])
        );
    end

    assign a_dout = dout_v[0];
    assign a_oe   = oe_v[0];
    assign b_dout = dout_v[1];
    assign b_oe   = oe_v[1];

endmodule

// File: rtl/ldrv_checker.sv
module ldrv_checker #(
    parameter int unsigned DATA_W  = 9,
    parameter int unsigned EN_PINS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DATA_W-1:0]  a_din,
    input logic [EN_PINS-1:0] a_en_n,
    input logic               a_test_sel,
    input logic [DATA_W-1:0]  a_test_data,
    input logic               a_test_oe,
    input logic [DATA_W-1:0]  b_din,
    input logic [EN_PINS-1:0] b_en_n,
    input logic               b_test_sel,
    input logic [DATA_W-1:0]  b_test_data,
    input logic               b_test_oe,
    input logic [DATA_W-1:0]  a_dout,
    input logic               a_oe,
    input logic [DATA_W-1:0]  b_dout,
    input logic               b_oe
);

    assert_pin_high_off_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_test_sel && a_en_n != '0) |-> !a_oe);
    assert_pin_high_off_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_test_sel && b_en_n != '0) |-> !b_oe);

    assert_pass_through_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_test_sel && a_oe) |-> (a_dout == a_din));
    assert_pass_through_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_test_sel && b_oe) |-> (b_dout == b_din));
    assert_off_zero_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !a_oe |-> (a_dout == '0));
    assert_off_zero_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe |-> (b_dout == '0));

    // A static low level with no prior enable never turns a byte on
    assert_static_low_off_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_test_sel && a_en_n == '0 && $past(a_en_n) == '0 &&
         !$past(a_test_sel) && !$past(a_oe)) |-> !a_oe);
    assert_static_low_off_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_test_sel && b_en_n == '0 && $past(b_en_n) == '0 &&
         !$past(b_test_sel) && !$past(b_oe)) |-> !b_oe);

    // Once on in system mode, stays on while both pins remain low
    assert_stay_armed_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && !a_test_sel) |=> ((!a_test_sel && a_en_n == '0) -> a_oe));
    assert_stay_armed_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !b_test_sel) |=> ((!b_test_sel && b_en_n == '0) -> b_oe));

    assert_override_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        a_test_sel |-> (a_oe == a_test_oe && (!a_test_oe || a_dout == a_test_data)));
    assert_override_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        b_test_sel |-> (b_oe == b_test_oe && (!b_test_oe || b_dout == b_test_data)));

    always_comb begin
        if (rst_n == 1'b0) begin
            assert_reset_off_R7: assert (!a_oe && !b_oe)
                else $error("outputs enabled during reset");
        end
    end

endmodule

bind dual_byte_line_driver ldrv_checker #(
    .DATA_W  (DATA_W),
    .EN_PINS (EN_PINS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_din       (a_din),
    .a_en_n      (a_en_n),
    .a_test_sel  (a_test_sel),
    .a_test_data (a_test_data),
    .a_test_oe   (a_test_oe),
    .b_din       (b_din),
    .b_en_n      (b_en_n),
    .b_test_sel  (b_test_sel),
    .b_test_data (b_test_data),
    .b_test_oe   (b_test_oe),
    .a_dout      (a_dout),
    .a_oe        (a_oe),
    .b_dout      (b_dout),
    .b_oe        (b_oe)
);

// File: tb/dual_byte_line_driver_tb_top.sv
module dual_byte_line_driver_tb_top;

    localparam int DW = 9;
    localparam int EP = 2;
    localparam int MAX_CYC = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [DW-1:0] din  [2];
    logic [EP-1:0] en   [2];
    logic          sel  [2];
    logic [DW-1:0] tdat [2];
    logic          toe  [2];
    logic [DW-1:0] a_dout, b_dout;
    logic          a_oe, b_oe;

    logic [EP-1:0] prev_m  [2];
    logic          armed_m [2];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    dual_byte_line_driver #(.DATA_W(DW), .EN_PINS(EP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_din(din[0]), .a_en_n(en[0]), .a_test_sel(sel[0]),
        .a_test_data(tdat[0]), .a_test_oe(toe[0]),
        .b_din(din[1]), .b_en_n(en[1]), .b_test_sel(sel[1]),
        .b_test_data(tdat[1]), .b_test_oe(toe[1]),
        .a_dout(a_dout), .a_oe(a_oe), .b_dout(b_dout), .b_oe(b_oe)
    );

    function automatic logic exp_oe(int b);
        logic fall;
        if (!rst_n) return 1'b0;
        if (sel[b]) return toe[b];
        fall = (en[b] == '0) && ((prev_m[b] & ~en[b]) != '0);
        return (en[b] == '0) && (armed_m[b] || fall);
    endfunction

    function automatic logic [DW-1:0] exp_dout(int b);
        if (!exp_oe(b)) return '0;
        return sel[b] ? tdat[b] : din[b];
    endfunction

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic get_oe(int b);
        return (b == 0) ? a_oe : b_oe;
    endfunction

    function automatic logic [DW-1:0] get_dout(int b);
        return (b == 0) ? a_dout : b_dout;
    endfunction

    // Compare both bytes mid-cycle, then advance the model at the edge
    task automatic step();
        @(negedge clk);
        for (int b = 0; b < 2; b++) begin
            string t_oe;
            logic eo;
            logic [DW-1:0] ed;
            eo = exp_oe(b);
            ed = exp_dout(b);
            if (!rst_n) t_oe = "R7";
            else if (sel[b]) t_oe = "R6";
            else if (en[b] != '0) t_oe = "R2";
            else t_oe = "R4";
            chk(get_oe(b) === eo, t_oe, DW'(get_oe(b)), DW'(eo));
            chk(get_dout(b) === ed, sel[b] ? "R6" : "R3", get_dout(b), ed);
        end
        @(posedge clk);
        for (int b = 0; b < 2; b++) begin
            if (!rst_n) begin
                armed_m[b] = 1'b0;
                prev_m[b]  = '0;
            end else begin
                if (en[b] == '0 && (prev_m[b] & ~en[b]) != '0) armed_m[b] = 1'b1;
                prev_m[b] = en[b];
            end
        end
        #1;
    endtask

    task automatic expect_oe(int b, logic v, string tag);
        chk(get_oe(b) === v, tag, DW'(get_oe(b)), DW'(v));
    endtask

    initial begin
        #(MAX_CYC * 8);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            din[b] = '0; en[b] = '0; sel[b] = 1'b1; tdat[b] = 9'h1A5; toe[b] = 1'b1;
            prev_m[b] = '0; armed_m[b] = 1'b0;
        end
        // R7: reset holds both bytes off even under test override
        repeat (3) step();
        expect_oe(0, 1'b0, "R7");
        expect_oe(1, 1'b0, "R7");
        sel[0] = 1'b0; sel[1] = 1'b0;
        din[0] = 9'h155; din[1] = 9'h0AA;
        rst_n = 1'b1;
        // R4: static low since reset never enables
        repeat (5) step();
        expect_oe(0, 1'b0, "R4");
        expect_oe(1, 1'b0, "R4");
        // R2/R8: pin 0 of byte A rises then falls -> A on, B untouched (R1)
        en[0] = 2'b01; step();
        expect_oe(0, 1'b0, "R2");
        en[0] = 2'b00; step();
        expect_oe(0, 1'b1, "R8");
        chk(a_dout === 9'h155, "R3", a_dout, 9'h155);
        expect_oe(1, 1'b0, "R1");
        // R5: armed byte follows pins without needing another edge later
        en[0] = 2'b10; step();
        expect_oe(0, 1'b0, "R2");
        en[0] = 2'b00; din[0] = 9'h0F3; step(); step();
        expect_oe(0, 1'b1, "R5");
        chk(a_dout === 9'h0F3, "R3", a_dout, 9'h0F3);
        // R6: override on unarmed byte B
        sel[1] = 1'b1; toe[1] = 1'b1; tdat[1] = 9'h13C; step();
        expect_oe(1, 1'b1, "R6");
        chk(b_dout === 9'h13C, "R6", b_dout, 9'h13C);
        toe[1] = 1'b0; step();
        expect_oe(1, 1'b0, "R6");
        expect_oe(0, 1'b1, "R1");
        sel[1] = 1'b0; step();
        expect_oe(1, 1'b0, "R4");
        // R8: pin 1 of byte B arms it
        en[1] = 2'b10; step();
        en[1] = 2'b00; step();
        expect_oe(1, 1'b1, "R8");
        chk(b_dout === 9'h0AA, "R3", b_dout, 9'h0AA);
        // R7: mid-run reset clears armed state
        rst_n = 1'b0; step();
        expect_oe(0, 1'b0, "R7");
        rst_n = 1'b1; repeat (3) step();
        expect_oe(0, 1'b0, "R7");
        expect_oe(1, 1'b0, "R7");

        // Random phase
        void'($urandom(32'd20240607));
        for (int i = 0; i < 3000; i++) begin
            for (int b = 0; b < 2; b++) begin
                din[b]  = DW'($urandom);
                tdat[b] = DW'($urandom);
                toe[b]  = 1'($urandom);
                if ($urandom_range(0, 3) == 0) en[b] = EP'($urandom);
                if ($urandom_range(0, 7) == 0) sel[b] = ~sel[b];
            end
            if ($urandom_range(0, 199) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
            step();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule